// File: doc/BRIEF.md
# Round-Robin Serial ADC Sampler

This block is a receive-only serial master that reads a group of external serial ADCs continuously, one after another, in a fixed channel order. All converters share one serial data input. The block produces the serial clock, selects exactly one converter per frame, shifts in the conversion MSB first and keeps the newest sample of every channel in a small result bank. Software or a neighbouring block reads the bank through a simple synchronous read port.

A two-bit profile input chooses the converter family. Profile 0 reads one quad converter that provides four 12-bit channels, addressed over two select lines. Profile 1 reads up to eight single-channel 15-bit converters. Profile 2 reads up to eight single-channel 16-bit converters. In profiles 1 and 2 the channel number is meant to drive an external 3-to-8 decoder. The sampler starts when the enable input is set and runs until the enable is cleared. A one-cycle pulse marks the end of each full pass over the channels.

Top module: `rr_adc_sampler`

## Requirements
- R1: The profile latched at start sets the frame length and the number of channels. Code 0 gives 12 bits over 4 channels. Code 1 gives 15 bits over 8 channels. Codes 2 and 3 give 16 bits over 8 channels. Each frame has exactly that many rising edges of `sclk`. On each rising edge `sdi` is shifted in, MSB first.
- R2: Frames visit the channels in the order 0, 1, … N-1, then 0 again. During a frame `cs_code` carries the channel number. While no frame is active, `cs_code` is all ones.
- R3: `sclk` is low whenever `cs_n` is high. Within a frame, `sclk` has a period of 2×D clock cycles, where D is `clk_div`. A `clk_div` of 0 acts as 1.
- R4: `cs_n` is low only during a frame, so only one converter is ever selected. `cs_code` does not change while `cs_n` stays low.
- R5: Between two consecutive frames, `cs_n` stays high for at least 4×D clock cycles, which is two `sclk` periods.
- R6: When `rd_en` is high at a clock edge, `rd_data` shows the result at `rd_addr` from the next cycle. Bit 16 is the valid flag. Bits 15:0 hold the sample right-aligned, with the upper bits zero. A channel never captured since reset reads with the valid flag at 0.
- R7: A capture sets the channel's valid flag, and a read of that channel clears it. If a capture and a read of the same channel fall on the same edge, the read returns the old content and the flag stays set. The next read then returns the new sample with the flag set.
- R8: `round_done` is high for exactly one cycle. It rises in the same cycle that `cs_n` rises after the last channel of a pass, and that channel's result is readable from then on.
- R9: Clearing `enable` lets the current frame finish and store its result. After that no further frame starts, `cs_n` stays high and `sclk` stays low.
- R10: A change of `mode` while the sampler runs has no effect on frame length or channel count. The new profile applies at the next start from idle.
- R11: While `rst` is high at a clock edge, the block goes idle: `cs_n`=1, `sclk`=0, `cs_code` all ones, `round_done`=0, `rd_data`=0 and all valid flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request for continuous sampling |
| mode | input | 2 | Converter profile, latched at start |
| clk_div | input | DIVW | Half-period of `sclk` in clock cycles (0 acts as 1) |
| sdi | input | 1 | Shared serial data from all converters |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low frame select or decoder enable |
| cs_code | output | AW | Channel number during a frame, all ones when idle |
| rd_en | input | 1 | Result read strobe |
| rd_addr | input | AW | Channel to read |
| rd_data | output | SW+1 | {valid, sample}, registered |
| round_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
A read of one channel can land on the same edge as the capture of that channel. This collision decides whether a fresh sample is reported or lost. The bench provokes it by holding `rd_en` high on a fixed address for two full passes, so that every capture of that channel meets a read. The collision is judged correct when each capture produces exactly one read cycle with the valid flag set, that read carries the value the converter model sent, and no other read cycle shows the flag.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GAP   = 2'd1,
    SEQ_FRAME = 2'd2
  } seq_state_e;

  // half-periods of sclk that cs_n stays high between frames
  localparam int GAP_HALVES = 4;
endpackage

// File: rtl/rrs_tick.sv
module rrs_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIVW'(1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt >= lim)  cnt <= '0;
    else                  cnt <= cnt + DIVW'(1);
  end
endmodule

// File: rtl/rrs_shift.sv
module rrs_shift #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          shift,
  input  logic          din,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk) begin
    if (clear)      q <= '0;
    else if (shift) q <= {q[SW-2:0], din};
  end
endmodule

// File: rtl/rrs_results.sv
module rrs_results #(
  parameter int NCH = 8,
  parameter int SW  = 16,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [SW:0]   rd_data
);
  logic [SW-1:0]  mem [NCH];
  logic [NCH-1:0] valid;
  logic [SW-1:0]  rd_word;
  logic           rd_vld;

  // plain write port, synchronous read: maps onto a RAM block
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_vld <= 1'b0;
    else if (rd_en) rd_vld <= valid[rd_addr];
  end

  // capture wins over read-clear on the same channel
  for (genvar i = 0; i < NCH; i++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)                                 valid[i] <= 1'b0;
      else if (wr_en && wr_addr == AW'(i))     valid[i] <= 1'b1;
      else if (rd_en && rd_addr == AW'(i))     valid[i] <= 1'b0;
    end
  end

  assign rd_data = {rd_vld, rd_word};
endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler
  import rrs_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int SW   = 16,
  parameter int DIVW = 8,
  parameter int W_A  = 12,
  parameter int N_A  = 4,
  parameter int W_B  = 15,
  parameter int N_B  = 8,
  parameter int W_C  = 16,
  parameter int N_C  = 8,
  localparam int AW  = $clog2(NCH),
  localparam int BCW = $clog2(SW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic [1:0]      mode,
  input  logic [DIVW-1:0] clk_div,
  input  logic            sdi,
  output logic            sclk,
  output logic            cs_n,
  output logic [AW-1:0]   cs_code,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [SW:0]     rd_data,
  output logic            round_done
);
  seq_state_e      state;
  logic [1:0]      amode;
  logic [AW-1:0]   ch;
  logic [BCW-1:0]  bits_left;
  logic [2:0]      gap_left;
  logic            tick;
  logic [SW-1:0]   shreg;
  int              prof_w;
  int              prof_n;
  logic            last_ch;
  logic            end_frame;
  logic            shift_en;
  logic            frame_start;

  // profile chosen by the latched mode; code 3 behaves as code 2
  always_comb begin
    case (amode)
      2'd0:    begin prof_w = W_A; prof_n = N_A; end
      2'd1:    begin prof_w = W_B; prof_n = N_B; end
      default: begin prof_w = W_C; prof_n = N_C; end
    endcase
  end

  assign last_ch     = (int'(ch) == prof_n - 1);
  assign shift_en    = (state == SEQ_FRAME) && tick && !sclk;
  assign end_frame   = (state == SEQ_FRAME) && tick && sclk && (bits_left == '0);
  assign frame_start = (state == SEQ_GAP) && tick && (gap_left == 3'd1) && enable;

  rrs_tick #(.DIVW(DIVW)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (state != SEQ_IDLE),
    .div  (clk_div),
    .tick (tick)
  );

  rrs_shift #(.SW(SW)) u_shift (
    .clk   (clk),
    .clear (rst || frame_start),
    .shift (shift_en),
    .din   (sdi),
    .q     (shreg)
  );

  rrs_results #(.NCH(NCH), .SW(SW)) u_res (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (end_frame),
    .wr_addr (ch),
    .wr_data (shreg),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      amode      <= 2'd0;
      ch         <= '0;
      bits_left  <= '0;
      gap_left   <= '0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      cs_code    <= '1;
      round_done <= 1'b0;
    end else begin
      round_done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (enable) begin
            amode    <= mode;
            ch       <= '0;
            gap_left <= 3'(GAP_HALVES);
            state    <= SEQ_GAP;
          end
        end
        SEQ_GAP: begin
          if (tick) begin
            if (gap_left == 3'd1) begin
              if (enable) begin
                cs_n      <= 1'b0;
                cs_code   <= ch;
                bits_left <= BCW'(prof_w);
                state     <= SEQ_FRAME;
              end else begin
                state <= SEQ_IDLE;
              end
            end else begin
              gap_left <= gap_left - 3'd1;
            end
          end
        end
        SEQ_FRAME: begin
          if (tick) begin
            if (!sclk) begin
              sclk      <= 1'b1;
              bits_left <= bits_left - BCW'(1);
            end else begin
              sclk <= 1'b0;
              if (bits_left == '0) begin
                cs_n       <= 1'b1;
                cs_code    <= '1;
                round_done <= last_ch;
                ch         <= last_ch ? '0 : ch + AW'(1);
                gap_left   <= 3'(GAP_HALVES);
                state      <= enable ? SEQ_GAP : SEQ_IDLE;
              end
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rr_adc_sampler_chk.sv
module rr_adc_sampler_chk #(
  parameter int DIVW = 8,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            sclk,
  input logic            cs_n,
  input logic [AW-1:0]   cs_code,
  input logic            round_done,
  input logic [DIVW-1:0] clk_div
);
  logic [11:0]     hi_cnt;
  logic [DIVW+2:0] gap_min;

  assign gap_min = (clk_div == '0) ? (DIVW+3)'(4) : (DIVW+3)'(clk_div) << 2;

  always_ff @(posedge clk) begin
    if (rst || !cs_n)          hi_cnt <= '0;
    else if (hi_cnt != '1)     hi_cnt <= hi_cnt + 12'd1;
  end

  // R2: idle select code is all ones
  a_r2_idle_code: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (cs_code == '1));

  // R3: no serial clock outside a frame
  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R4: channel select steady through a frame
  a_r4_code_stable: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> $stable(cs_code));

  // R5: deselect time before every frame
  a_r5_gap_min: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (32'(hi_cnt) >= 32'(gap_min)));

  // R8: single-cycle pulse tied to the end of a frame
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
    round_done |=> !round_done);

  a_r8_pulse_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    round_done |-> $rose(cs_n));
endmodule

bind rr_adc_sampler rr_adc_sampler_chk #(.DIVW(DIVW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .cs_code    (cs_code),
  .round_done (round_done),
  .clk_div    (clk_div)
);

// File: tb/rr_adc_sampler_tb.sv
module rr_adc_sampler_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst, enable, sdi, rd_en;
  logic [1:0]  mode;
  logic [7:0]  clk_div;
  logic [2:0]  rd_addr;
  logic        sclk, cs_n, round_done;
  logic [2:0]  cs_code;
  logic [16:0] rd_data;

  rr_adc_sampler u_dut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .clk_div(clk_div),
    .sdi(sdi), .sclk(sclk), .cs_n(cs_n), .cs_code(cs_code),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .round_done(round_done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  // converter model and monitor settings
  int          mw = 12, mn = 4, mdiv = 1;
  int          sent [8];
  logic [15:0] last_val [8];
  bit          mon_on = 1'b0;
  int          exp_ch = 0, hi_cnt = 0, since_rise = 0, rises = 0, fcode = 0;
  bit          have_prev = 1'b0;
  logic        p_cs = 1'b1, p_sclk = 1'b0, p_rd = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int eff();
    return (mdiv == 0) ? 1 : mdiv;
  endfunction

  function automatic logic [15:0] smp(input int c, input int n, input int w);
    logic [15:0] v;
    v = 16'(c * 32'h2E1B) ^ 16'(n * 32'h0F35) ^ 16'hA5C3;
    return v & 16'((32'h1 << w) - 1);
  endfunction

  task automatic set_prof(input int md, input int dv);
    mode = 2'(md); clk_div = 8'(dv); mdiv = dv;
    case (md)
      0:       begin mw = 12; mn = 4; end
      1:       begin mw = 15; mn = 8; end
      default: begin mw = 16; mn = 8; end
    endcase
    exp_ch = 0; have_prev = 1'b0;
  endtask

  task automatic rd(input int a, output logic [16:0] d);
    @(negedge clk);
    rd_addr = 3'(a); rd_en = 1'b1;
    @(negedge clk);
    d = rd_data; rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); enable = 1'b0;
    repeat (8 * eff() + 4) @(negedge clk);
  endtask

  task automatic check_bank(input bit unused_empty);
    logic [16:0] d;
    for (int c = 0; c < 8; c++) begin
      if (c < mn) begin
        rd(c, d);
        chk(d[16] == 1'b1, "R7 valid after capture", int'(d[16]), 1);
        chk(d[15:0] == last_val[c], "R1 R6 stored sample", int'(d[15:0]), int'(last_val[c]));
        rd(c, d);
        chk(d[16] == 1'b0, "R7 valid cleared by read", int'(d[16]), 0);
      end else if (unused_empty) begin
        rd(c, d);
        chk(d[16] == 1'b0, "R6 unused channel empty", int'(d[16]), 0);
      end
    end
  endtask

  task automatic run_mode(input int md, input int dv, input int rounds, input bit unused_empty);
    set_prof(md, dv);
    @(negedge clk); enable = 1'b1;
    repeat (rounds * mn) @(posedge cs_n);
    wait_idle();
    chk(cs_n == 1'b1 && sclk == 1'b0, "R9 idle after stop", int'({cs_n, sclk}), 2);
    check_bank(unused_empty);
  endtask

  // converter model: drives the next bit after each falling sclk
  initial begin : adc_model
    int c;
    logic [15:0] v;
    sdi = 1'b0;
    for (int i = 0; i < 8; i++) sent[i] = 0;
    forever begin
      @(negedge cs_n);
      c = int'(cs_code);
      v = smp(c, sent[c], mw);
      last_val[c] = v;
      for (int b = mw - 1; b >= 0; b--) begin
        sdi = v[b];
        @(negedge sclk);
      end
      sent[c]++;
    end
  end

  // frame monitor
  initial begin : frame_mon
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (p_cs && !cs_n) begin
          fcode = int'(cs_code);
          chk(fcode == exp_ch, "R2 channel order", fcode, exp_ch);
          if (have_prev) chk(hi_cnt >= 4 * eff(), "R5 deselect gap", hi_cnt, 4 * eff());
          rises = 0;
        end
        if (!cs_n && !p_sclk && sclk) begin
          if (rises > 0) chk(since_rise == 2 * eff(), "R3 sclk period", since_rise, 2 * eff());
          chk(int'(cs_code) == fcode, "R4 select stable", int'(cs_code), fcode);
          rises++;
          since_rise = 0;
        end
        if (!p_cs && cs_n) begin
          chk(rises == mw, "R1 bits per frame", rises, mw);
          chk(round_done == (fcode == mn - 1), "R8 pass pulse", int'(round_done), int'(fcode == mn - 1));
          chk(cs_code == 3'b111, "R2 idle code", int'(cs_code), 7);
          exp_ch = (exp_ch + 1) % mn;
          have_prev = 1'b1;
          hi_cnt = 0;
        end
        if (p_rd) chk(round_done == 1'b0, "R8 pulse one cycle", int'(round_done), 0);
      end
      if (cs_n) hi_cnt++;
      since_rise++;
      p_cs = cs_n; p_sclk = sclk; p_rd = round_done;
    end
  end

  initial begin : watchdog
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin : main
    logic [16:0] d;
    int viol, hits, passes;
    rst = 1'b1; enable = 1'b0; mode = 2'd0; clk_div = 8'd0;
    rd_en = 1'b0; rd_addr = 3'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk(cs_n == 1'b1, "R11 cs_n after reset", int'(cs_n), 1);
    chk(sclk == 1'b0, "R11 sclk after reset", int'(sclk), 0);
    chk(cs_code == 3'b111, "R11 code after reset", int'(cs_code), 7);
    chk(round_done == 1'b0, "R11 pulse after reset", int'(round_done), 0);
    chk(rd_data == 17'd0, "R11 read data after reset", int'(rd_data), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d[16] == 1'b0, "R11 valid clear after reset", int'(d[16]), 0);
    end

    mon_on = 1'b1;
    run_mode(0, 0, 2, 1'b1);   // R1 quad profile, R3 divider 0 acts as 1
    run_mode(1, 2, 1, 1'b0);   // R1 15-bit profile
    run_mode(2, 3, 1, 1'b0);   // R1 16-bit profile
    run_mode(3, 1, 1, 1'b0);   // R1 code 3 behaves as code 2

    // R9 stop in the middle of the third frame
    set_prof(1, 2);
    @(negedge clk); enable = 1'b1;
    repeat (3) @(negedge cs_n);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(posedge cs_n);
    viol = 0;
    repeat (300) begin
      @(negedge clk);
      if (!cs_n || sclk) viol++;
    end
    chk(viol == 0, "R9 no frame after stop", viol, 0);
    rd(2, d);
    chk(d[16] == 1'b1 && d[15:0] == last_val[2], "R9 last frame stored", int'(d), int'({1'b1, last_val[2]}));
    rd(3, d);
    chk(d[16] == 1'b0, "R9 no capture after stop", int'(d[16]), 0);

    // R7 capture and read of the same channel on one edge
    set_prof(2, 2);
    @(negedge clk); rd_addr = 3'd5; rd_en = 1'b1;
    @(negedge clk); enable = 1'b1;
    hits = 0; passes = 0;
    while (passes < 2) begin
      @(negedge clk);
      if (rd_data[16]) begin
        hits++;
        chk(rd_data[15:0] == last_val[5], "R7 collision data", int'(rd_data[15:0]), int'(last_val[5]));
      end
      if (round_done) passes++;
    end
    repeat (3) @(negedge clk);
    if (rd_data[16]) hits++;
    chk(hits == 2, "R7 one valid read per capture", hits, 2);
    rd_en = 1'b0;
    wait_idle();

    // R10 mode change while running is ignored
    set_prof(1, 1);
    @(negedge clk); enable = 1'b1;
    repeat (3) @(posedge cs_n);
    @(negedge clk); mode = 2'd0;
    repeat (9) @(posedge cs_n);
    wait_idle();
    chk(sent[7] >= 1, "R10 eight channels kept", sent[7], 1);
    run_mode(0, 1, 1, 1'b0);   // R10 new profile applies on restart

    mon_on = 1'b0;
    finish_up();
  end
endmodule